// File: doc/BRIEF.md
# Infrared Keypad Frame Transmitter

This block turns one key event on a classroom response keypad into the serial chip stream that drives the infrared LED. When a key event is accepted, it takes the key number and the keypad's 16-bit identity number. It builds a 36-bit word from them, ending in an additive checksum, and sends that word as a burst of three-chip symbols. After a dark gap it sends a second burst that carries the same word with every data bit inverted.

Chip and gap durations are counted in pulses of a single rate-enable input. The system integrator sets that pulse rate so that one chip lasts about half a millisecond. Letter keys start a frame when they are pressed. The back key starts a frame when it is released. Any key event that arrives while a frame is in flight is dropped.

Top module: `ir_keypad_tx`

## Requirements
- R1: After reset, and at all times while `busy` is low, `led` is 0 and `busy` is 0.
- R2: A frame starts on `key_press` when `key_sel` is 1 to 5 (letter keys), and on `key_release` when `key_sel` is 6 (back key). A press of key 6, a release of keys 1 to 5, and any event with `key_sel` 0 or 7 start nothing.
- R3: The word is 36 bits and is sent MSB first. Bits 35:32 hold the key code `{1'b1, key_sel}`, bits 31:24 are zero, bits 23:8 hold `tx_id`, and bits 7:0 hold the checksum.
- R4: The checksum is the sum modulo 256 of the zero-extended key code, the zero byte, `tx_id[15:8]` and `tx_id[7:0]`. Any carry out of bit 7 is discarded.
- R5: Each data bit is sent as three chips in the order 0, 1, then the bit value.
- R6: Each chip lasts exactly CHIP_TICKS pulses of `tick`. The first chip begins on the clock edge that accepts the key event.
- R7: Between the two bursts, `led` stays 0 for exactly GAP_TICKS pulses of `tick`.
- R8: The second burst uses the same chip pattern as the first, but every data chip is inverted. The 0 and 1 delimiter chips are not inverted.
- R9: `busy` rises on the accepting edge and falls on the edge that ends the last chip of the second burst. A key event that arrives while `busy` is high is ignored.
- R10: `key_sel` and `tx_id` are sampled only on the accepting edge. Later changes to them do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Chip-rate enable, one clock wide |
| key_press | input | 1 | Key-down event strobe |
| key_release | input | 1 | Key-up event strobe |
| key_sel | input | 3 | Key number, 1 to 5 for letters and 6 for back |
| tx_id | input | 16 | Keypad identity number |
| led | output | 1 | LED drive chip stream |
| busy | output | 1 | High while a frame is being sent |

## Verification
A wrong bit or chip index shows up at `led` within one chip period. A data-chip error appears as a wrong level at the third chip of a symbol. A delimiter slip appears as three equal chips in a row. A checksum fault shows on the last eight symbols of the first burst and again, inverted, in the second burst. A miscounted tick counter shifts every later edge of `led` and `busy`, so a comparison on every clock catches it at the first chip boundary. A latched word that is overwritten by a late key event or identity change shows as a data-chip mismatch at the next affected bit.

// File: rtl/ir_keypad_pkg.sv
package ir_keypad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } tx_state_e;

    localparam int unsigned SYM_CHIPS = 3;   // 0, 1, data
    localparam int unsigned CHIP_W    = 2;

endpackage

// File: rtl/ir_key_qualifier.sv
module ir_key_qualifier #(
    parameter int unsigned KEY_W       = 3,
    parameter int unsigned NUM_LETTERS = 5,
    localparam int unsigned CODE_W     = KEY_W + 1,
    localparam int unsigned BACK_KEY   = NUM_LETTERS + 1
) (
    input  logic              key_press,
    input  logic              key_release,
    input  logic [KEY_W-1:0]  key_sel,
    output logic              fire,
    output logic [CODE_W-1:0] code
);

    logic is_letter;
    logic is_back;

    always_comb begin
        is_letter = (key_sel >= KEY_W'(1)) && (key_sel <= KEY_W'(NUM_LETTERS));
        is_back   = (key_sel == KEY_W'(BACK_KEY));
        // letters fire on key-down, the back key on key-up
        fire      = (key_press && is_letter) || (key_release && is_back);
        code      = {1'b1, key_sel};
    end

endmodule

// File: rtl/ir_frame_builder.sv
module ir_frame_builder #(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned PAD_W    = 8,
    parameter int unsigned ID_W     = 16,
    parameter int unsigned SUM_W    = 8,
    localparam int unsigned WORD_W  = CODE_W + PAD_W + ID_W + SUM_W,
    localparam int unsigned ID_BYTES = ID_W / SUM_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic [ID_W-1:0]   id,
    output logic [WORD_W-1:0] word
);

    // running modular sum; the zero pad contributes nothing
    logic [SUM_W-1:0] acc [ID_BYTES+1];

    assign acc[0] = SUM_W'(code);

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_sum
        assign acc[g+1] = acc[g] + id[g*SUM_W +: SUM_W];
    end

    assign word = {code, {PAD_W{1'b0}}, id, acc[ID_BYTES]};

endmodule

// File: rtl/ir_tick_counter.sv
module ir_tick_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = !clear && tick && (cnt_q == limit - CNT_W'(1));
        cnt_d = cnt_q;
        if (clear || hit) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit) else $error("tick counter out of range"); // R6

endmodule

// File: rtl/ir_keypad_tx.sv
module ir_keypad_tx #(
    parameter int unsigned CHIP_TICKS  = 4,
    parameter int unsigned GAP_TICKS   = 72,
    parameter int unsigned KEY_W       = 3,
    parameter int unsigned NUM_LETTERS = 5,
    parameter int unsigned ID_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_press,
    input  logic             key_release,
    input  logic [KEY_W-1:0] key_sel,
    input  logic [ID_W-1:0]  tx_id,
    output logic             led,
    output logic             busy
);
    import ir_keypad_pkg::*;

    localparam int unsigned CODE_W = KEY_W + 1;
    localparam int unsigned PAD_W  = 8;
    localparam int unsigned SUM_W  = 8;
    localparam int unsigned WORD_W = CODE_W + PAD_W + ID_W + SUM_W;
    localparam int unsigned BIT_W  = $clog2(WORD_W);
    localparam int unsigned MAX_T  = (GAP_TICKS > CHIP_TICKS) ? GAP_TICKS : CHIP_TICKS;
    localparam int unsigned CNT_W  = $clog2(MAX_T + 1);

    typedef struct packed {
        tx_state_e          state;
        logic               inv;
        logic [BIT_W-1:0]   bit_idx;
        logic [CHIP_W-1:0]  chip;
        logic [WORD_W-1:0]  word;
        logic               led;
    } tx_reg_t;

    tx_reg_t r_d, r_q;

    logic              fire;
    logic [CODE_W-1:0] code;
    logic [WORD_W-1:0] built;
    logic              hit;
    logic [CNT_W-1:0]  limit;
    logic              cnt_clear;

    ir_key_qualifier #(.KEY_W(KEY_W), .NUM_LETTERS(NUM_LETTERS)) u_qual (
        .key_press   (key_press),
        .key_release (key_release),
        .key_sel     (key_sel),
        .fire        (fire),
        .code        (code)
    );

    ir_frame_builder #(.CODE_W(CODE_W), .PAD_W(PAD_W), .ID_W(ID_W), .SUM_W(SUM_W)) u_build (
        .code (code),
        .id   (tx_id),
        .word (built)
    );

    assign limit     = (r_q.state == ST_GAP) ? CNT_W'(GAP_TICKS) : CNT_W'(CHIP_TICKS);
    assign cnt_clear = (r_q.state == ST_IDLE);

    ir_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (tick),
        .limit (limit),
        .hit   (hit)
    );

    function automatic logic chip_level(input logic [CHIP_W-1:0] c,
                                        input logic              data,
                                        input logic              inv);
        if (c == CHIP_W'(0))      return 1'b0;
        else if (c == CHIP_W'(1)) return 1'b1;
        else                      return data ^ inv;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (fire) begin
                    r_d.state   = ST_BURST;
                    r_d.inv     = 1'b0;
                    r_d.bit_idx = BIT_W'(WORD_W - 1);
                    r_d.chip    = '0;
                    r_d.word    = built;
                end
            end
            ST_BURST: begin
                if (hit) begin
                    if (r_q.chip == CHIP_W'(SYM_CHIPS - 1)) begin
                        r_d.chip = '0;
                        if (r_q.bit_idx == '0) begin
                            r_d.state = r_q.inv ? ST_IDLE : ST_GAP;
                        end else begin
                            r_d.bit_idx = r_q.bit_idx - BIT_W'(1);
                        end
                    end else begin
                        r_d.chip = r_q.chip + CHIP_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (hit) begin
                    r_d.state   = ST_BURST;
                    r_d.inv     = 1'b1;
                    r_d.bit_idx = BIT_W'(WORD_W - 1);
                    r_d.chip    = '0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.led = (r_d.state == ST_BURST)
                ? chip_level(r_d.chip, r_d.word[r_d.bit_idx], r_d.inv)
                : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, inv: 1'b0, bit_idx: '0, chip: '0, word: '0, led: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign led  = r_q.led;
    assign busy = (r_q.state != ST_IDLE);

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !led) else $error("led lit while idle"); // R1

    AST_DELIM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BURST && r_q.chip == '0 && hit) |=> led)
        else $error("second delimiter chip not high"); // R5

    AST_SYMBOL_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BURST && r_q.chip == CHIP_W'(SYM_CHIPS - 1) && r_q.bit_idx != '0 && hit)
        |=> !led) else $error("symbol did not open with a low chip"); // R5

    AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_GAP) |-> !led) else $error("led lit in gap"); // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(r_q.state == ST_BURST && r_q.inv && r_q.bit_idx == '0 && hit)) |=> busy)
        else $error("busy dropped early"); // R9

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(r_q.word)) else $error("latched word changed"); // R10

endmodule

// File: tb/ir_keypad_tx_tb.sv
`timescale 1ns/1ps
module ir_keypad_tx_tb;

    localparam int CT = 3;
    localparam int GT = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        key_press = 1'b0;
    logic        key_release = 1'b0;
    logic [2:0]  key_sel = 3'd0;
    logic [15:0] tx_id = 16'h0000;
    logic        led;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;

    always #2 clk = ~clk;

    ir_keypad_tx #(.CHIP_TICKS(CT), .GAP_TICKS(GT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_press(key_press),
        .key_release(key_release), .key_sel(key_sel), .tx_id(tx_id),
        .led(led), .busy(busy)
    );

    // ---------------- behavioural reference ----------------
    typedef struct { int val; int ticks; int tag; } seg_t;
    seg_t seg_q[$];
    seg_t cur;
    bit   m_busy = 1'b0;

    function automatic logic [35:0] exp_word(input logic [2:0] k, input logic [15:0] id);
        int s;
        s = (8 + int'(k)) + 0 + int'(id[15:8]) + int'(id[7:0]);  // R4 sum mod 256
        return {1'b1, k, 8'h00, id, 8'(s % 256)};                 // R3 layout
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            3: return "R3";
            5: return "R5";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic load_frame(input logic [35:0] w);
        for (int b = 0; b < 2; b++) begin
            for (int i = 35; i >= 0; i--) begin
                seg_q.push_back('{0, CT, 5});                  // R5 low delimiter
                seg_q.push_back('{1, CT, 5});                  // R5 high delimiter
                seg_q.push_back('{int'(w[i]) ^ b, CT, (b == 0) ? 3 : 8});
            end
            if (b == 0) seg_q.push_back('{0, GT, 7});          // R7 dark gap
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            seg_q.delete();
        end else if (m_busy) begin
            if (tick) begin
                cur.ticks--;                                    // R6 tick-counted chips
                if (cur.ticks == 0) begin
                    if (seg_q.size() == 0) m_busy = 1'b0;
                    else cur = seg_q.pop_front();
                end
            end
        end else if ((key_press && key_sel >= 1 && key_sel <= 5) ||
                     (key_release && key_sel == 6)) begin      // R2 trigger rules
            load_frame(exp_word(key_sel, tx_id));               // R10 sampled here
            cur = seg_q.pop_front();
            m_busy = 1'b1;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            logic exp_led;
            exp_led = m_busy ? cur.val[0] : 1'b0;
            checks++;
            if (led !== exp_led) begin
                errors++;
                $display("FAIL %s (chip timing R6) led at cycle %0d: actual %b expected %b",
                         m_busy ? tag_name(cur.tag) : "R1", cyc, led, exp_led);
            end
            checks++;
            if (busy !== m_busy) begin
                errors++;
                $display("FAIL R9 busy at cycle %0d: actual %b expected %b", cyc, busy, m_busy);
            end
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // tick generator driven away from the clock edge
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n >= tick_div) begin tick = 1'b1; n = 0; end
            else tick = 1'b0;
        end
    end

    task automatic pulse(input bit rel, input logic [2:0] k);
        @(negedge clk);
        key_sel = k;
        if (rel) key_release = 1'b1; else key_press = 1'b1;
        @(negedge clk);
        key_press = 1'b0;
        key_release = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy || busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_quiet(input string what);
        repeat (4) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || led !== 1'b0) begin
            errors++;
            $display("FAIL R2 %s: actual busy=%b led=%b expected busy=0 led=0", what, busy, led);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (led !== 1'b0 || busy !== 1'b0) begin   // R1 reset state
            errors++;
            $display("FAIL R1 reset: actual led=%b busy=%b expected 0 0", led, busy);
        end
        rst_n = 1'b1;

        // bench self-consistency of the known word (R4 wrap not hit here)
        checks++;
        if (exp_word(3'd1, 16'hD915) !== 36'h9_00_D9_15_F7) begin
            errors++;
            $display("FAIL R4 reference word: actual %h expected 900d915f7", exp_word(3'd1, 16'hD915));
        end

        tx_id = 16'hD915;
        pulse(1'b0, 3'd1);                       // R3 letter key, tick every cycle
        wait_idle();

        pulse(1'b0, 3'd6);                       // R2 back key press ignored
        expect_quiet("back-key press");
        pulse(1'b1, 3'd3);                       // R2 letter release ignored
        expect_quiet("letter release");
        pulse(1'b0, 3'd0);
        expect_quiet("key 0 press");
        pulse(1'b0, 3'd7);
        expect_quiet("key 7 press");

        tick_div = 2;
        tx_id = 16'h1234;
        pulse(1'b1, 3'd6);                       // R2 back key on release
        wait_idle();

        tick_div = 3;
        tx_id = 16'hA5C3;
        pulse(1'b0, 3'd5);
        repeat (200) @(negedge clk);
        tx_id = 16'h0F0F;                        // R10 change mid-frame
        pulse(1'b0, 3'd2);                       // R9 press while busy ignored
        pulse(1'b1, 3'd6);
        wait_idle();

        tick_div = 1;
        tx_id = 16'hFFFF;                        // R4 checksum carry dropped
        pulse(1'b0, 3'd4);
        @(negedge clk);
        while (busy) @(negedge clk);
        tx_id = 16'h8001;
        pulse(1'b0, 3'd3);                       // back-to-back frame
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule